// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block is the programming side of a direct digital synthesizer. A host shifts 16-bit words into it over three wires: a frame-select line (active low), a serial clock and a serial data line. The block samples the three wires in the master clock domain and rebuilds each word there. It decodes the top bits of the word as an address. The word then lands in one of five registers: a 16-bit control word, two 28-bit frequency tuning words or two 12-bit phase offsets.

A full 28-bit frequency value is larger than the 14 payload bits of one word. In paired mode the first write is held in a staging register, and the target register changes in one step when the second write arrives. In single mode a control bit picks which 14-bit half a write replaces. The synthesis core reads all register contents and the soft-reset control bit as plain outputs.

The serial wires are oversampled, so the master clock must run at least four times faster than the serial clock. Each serial clock level must last at least two master clock periods.

Top module: `dds_prog_port`

## Requirements
- R1: A frame opens while frameSelN is low. Data bits are sampled on each falling edge of serClk, most significant bit first. The word is taken after the 16th falling edge of the frame.
- R2: If frameSelN rises before 16 falling edges, the partial word is dropped and no register changes. Falling edges after the 16th in the same frame are ignored.
- R3: A word whose bits 15:14 are 00 is stored whole as the control word. The coreReset output follows control bit 8.
- R4: Setting control bit 8 leaves the frequency and phase registers unchanged.
- R5: Bits 15:14 equal to 01 address frequency register 0, and 10 addresses frequency register 1. The payload is bits 13:0.
- R6: With control bit 13 set, the first frequency write only stages its 14 bits, and the register does not change. A second write to the same register loads {second payload, staged payload} in a single update.
- R7: In paired mode, a write to the other frequency register while a half is pending restarts staging for that register. Any control word write discards a pending half.
- R8: With control bit 13 clear, a frequency write replaces only bits 27:14 when control bit 12 is 1, and only bits 13:0 when it is 0.
- R9: Bits 15:13 equal to 110 address phase register 0, and 111 addresses phase register 1. The register takes bits 11:0, and bit 12 is ignored.
- R10: While rstN is low, every register and the staging state are cleared to zero, and coreReset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| frameSelN | input | 1 | Frame select, low while a word is shifted |
| serClk | input | 1 | Serial clock, idles high, data taken on falling edge |
| serData | input | 1 | Serial data, most significant bit first |
| ctrlWord | output | 16 | Control register contents |
| coreReset | output | 1 | Soft-reset bit for the synthesis core (control bit 8) |
| freqWord0 | output | 28 | Frequency register 0 |
| freqWord1 | output | 28 | Frequency register 1 |
| phaseWord0 | output | 12 | Phase register 0 |
| phaseWord1 | output | 12 | Phase register 1 |

## Verification
The assertions check properties that hold on every cycle. The bit counter never passes 16, and a taken word is a one-cycle pulse. At most one register write is issued per word. A pending staged half exists only in paired mode. Each register stays stable unless a write strobe targets it, and an upper-half write leaves the lower 14 bits alone. Only the bench's scenarios can show the value-level results. These are the exact 28-bit result of a paired load, the restart and discard of a pending half, truncated and overlong frames, and the fact that bit 12 is ignored in phase words. The bench compares every output against its own register model after each frame.

// File: rtl/dds_prog_pkg.sv
package dds_prog_pkg;
  localparam int DDS_WORD_W = 16;
  localparam int DDS_HALF_W = DDS_WORD_W - 2;
  localparam int DDS_FREQ_W = 2 * DDS_HALF_W;

  typedef enum logic [1:0] {
    FOP_STAGE = 2'd0,
    FOP_FULL  = 2'd1,
    FOP_UPPER = 2'd2,
    FOP_LOWER = 2'd3
  } freqOp_e;

  typedef struct packed {
    logic                  ctrlWr;
    logic                  freqWr;
    logic                  freqSel;
    freqOp_e               freqOp;
    logic                  phaseWr;
    logic                  phaseSel;
    logic [DDS_HALF_W-1:0] payload;
  } dpCmd_t;
endpackage

// File: rtl/dds_ser_capture.sv
module dds_ser_capture
  import dds_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameSelN,
  input  logic                  serClk,
  input  logic                  serData,
  output logic                  wordValid,
  output logic [DDS_WORD_W-1:0] wordOut
);
  localparam int CNT_W = $clog2(DDS_WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclkSync, fselSync, sdatSync;
  logic                   sclkPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic [DDS_WORD_W-1:0]  shiftReg;

  wire sclkS  = sclkSync[SYNC_STAGES-1];
  wire fselS  = fselSync[SYNC_STAGES-1];
  wire sdatS  = sdatSync[SYNC_STAGES-1];
  wire fallEv = sclkPrev & ~sclkS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '1;
      fselSync <= '1;
      sdatSync <= '0;
      sclkPrev <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], serClk};
      fselSync <= {fselSync[SYNC_STAGES-2:0], frameSelN};
      sdatSync <= {sdatSync[SYNC_STAGES-2:0], serData};
      sclkPrev <= sclkS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (fselS) begin
        bitCnt <= '0;
      end else if (fallEv && (bitCnt < CNT_W'(DDS_WORD_W))) begin
        shiftReg <= {shiftReg[DDS_WORD_W-2:0], sdatS};
        bitCnt   <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(DDS_WORD_W - 1)) wordValid <= 1'b1;
      end
    end
  end

  assign wordOut = shiftReg;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DDS_WORD_W));

  // R1
  word_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
endmodule

// File: rtl/dds_prog_ctrl.sv
module dds_prog_ctrl
  import dds_prog_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wordValid,
  input  logic [DDS_WORD_W-1:0] wordIn,
  input  logic                  pairMode,
  input  logic                  upperSel,
  output dpCmd_t                cmd
);
  logic pending;
  logic pendSel;

  wire [1:0] addrTop = wordIn[DDS_WORD_W-1 -: 2];
  wire       isCtrl  = wordValid && (addrTop == 2'b00);
  wire       isFreq  = wordValid && ((addrTop == 2'b01) || (addrTop == 2'b10));
  wire       isPhase = wordValid && (addrTop == 2'b11);
  wire       fSel    = (addrTop == 2'b10);
  wire       closing = pending && (pendSel == fSel);

  always_comb begin
    cmd          = '0;
    cmd.payload  = wordIn[DDS_HALF_W-1:0];
    cmd.ctrlWr   = isCtrl;
    cmd.freqWr   = isFreq;
    cmd.freqSel  = fSel;
    cmd.phaseWr  = isPhase;
    cmd.phaseSel = wordIn[DDS_WORD_W-3];
    if (pairMode)      cmd.freqOp = closing ? FOP_FULL : FOP_STAGE;
    else if (upperSel) cmd.freqOp = FOP_UPPER;
    else               cmd.freqOp = FOP_LOWER;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      pendSel <= 1'b0;
    end else if (isCtrl) begin
      pending <= 1'b0;
    end else if (isFreq && pairMode) begin
      pending <= !closing;
      pendSel <= fSel;
    end
  end

  // R7
  pend_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> pairMode);

  // R3
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmd.ctrlWr, cmd.freqWr, cmd.phaseWr}) <= 1);
endmodule

// File: rtl/dds_prog_dp.sv
module dds_prog_dp
  import dds_prog_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  output logic [DDS_WORD_W-1:0] ctrlWord,
  output logic [DDS_FREQ_W-1:0] freqWord0,
  output logic [DDS_FREQ_W-1:0] freqWord1,
  output logic [PHASE_W-1:0]    phaseWord0,
  output logic [PHASE_W-1:0]    phaseWord1
);
  localparam int NREG = 2;

  logic [DDS_WORD_W-1:0] ctrlReg;
  logic [DDS_HALF_W-1:0] stageReg;
  logic [DDS_FREQ_W-1:0] freqReg  [NREG];
  logic [PHASE_W-1:0]    phaseReg [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      stageReg <= '0;
      for (int i = 0; i < NREG; i++) begin
        freqReg[i]  <= '0;
        phaseReg[i] <= '0;
      end
    end else begin
      if (cmd.ctrlWr) ctrlReg <= {2'b00, cmd.payload};
      if (cmd.freqWr && cmd.freqOp == FOP_STAGE) stageReg <= cmd.payload;
      for (int i = 0; i < NREG; i++) begin
        if (cmd.freqWr && (cmd.freqSel == i[0])) begin
          case (cmd.freqOp)
            FOP_FULL:  freqReg[i] <= {cmd.payload, stageReg};
            FOP_UPPER: freqReg[i][DDS_FREQ_W-1:DDS_HALF_W] <= cmd.payload;
            FOP_LOWER: freqReg[i][DDS_HALF_W-1:0] <= cmd.payload;
            default:   ;
          endcase
        end
        if (cmd.phaseWr && (cmd.phaseSel == i[0]))
          phaseReg[i] <= cmd.payload[PHASE_W-1:0];
      end
    end
  end

  assign ctrlWord   = ctrlReg;
  assign freqWord0  = freqReg[0];
  assign freqWord1  = freqReg[1];
  assign phaseWord0 = phaseReg[0];
  assign phaseWord1 = phaseReg[1];

  // R4
  f0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.freqWr && !cmd.freqSel) |=> $stable(freqWord0));

  // R9
  ph_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.phaseWr |=> ($stable(phaseWord0) && $stable(phaseWord1)));

  // R8
  upper_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.freqWr && cmd.freqSel && cmd.freqOp == FOP_UPPER)
      |=> freqWord1[DDS_HALF_W-1:0] == $past(freqWord1[DDS_HALF_W-1:0]));
endmodule

// File: rtl/dds_prog_port.sv
module dds_prog_port
  import dds_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PHASE_W     = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameSelN,
  input  logic                  serClk,
  input  logic                  serData,
  output logic [DDS_WORD_W-1:0] ctrlWord,
  output logic                  coreReset,
  output logic [DDS_FREQ_W-1:0] freqWord0,
  output logic [DDS_FREQ_W-1:0] freqWord1,
  output logic [PHASE_W-1:0]    phaseWord0,
  output logic [PHASE_W-1:0]    phaseWord1
);
  localparam int RST_BIT   = 8;
  localparam int UPPER_BIT = 12;
  localparam int PAIR_BIT  = 13;

  logic                  wordValid;
  logic [DDS_WORD_W-1:0] wordBus;
  dpCmd_t                cmd;

  dds_ser_capture #(.SYNC_STAGES(SYNC_STAGES)) cap_i (
    .clk(clk), .rstN(rstN), .frameSelN(frameSelN), .serClk(serClk),
    .serData(serData), .wordValid(wordValid), .wordOut(wordBus)
  );

  dds_prog_ctrl ctl_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordBus),
    .pairMode(ctrlWord[PAIR_BIT]), .upperSel(ctrlWord[UPPER_BIT]), .cmd(cmd)
  );

  dds_prog_dp #(.PHASE_W(PHASE_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ctrlWord(ctrlWord),
    .freqWord0(freqWord0), .freqWord1(freqWord1),
    .phaseWord0(phaseWord0), .phaseWord1(phaseWord1)
  );

  assign coreReset = ctrlWord[RST_BIT];

  // R10
  rst_zero_chk: assert property (@(posedge clk)
    !rstN |=> (ctrlWord == '0 && freqWord0 == '0 && phaseWord1 == '0));
endmodule

// File: tb/dds_prog_port_tb_top.sv
module dds_prog_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSelN = 1'b1;
  logic serClk = 1'b1;
  logic serData = 1'b0;
  logic [15:0] ctrlWord;
  logic        coreReset;
  logic [27:0] freqWord0, freqWord1;
  logic [11:0] phaseWord0, phaseWord1;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] mCtrl;
  logic [27:0] mF0, mF1;
  logic [11:0] mP0, mP1;
  logic [13:0] mStage;
  logic        mPend, mPendSel;

  always #5 clk = ~clk;

  dds_prog_port dut_i (
    .clk(clk), .rstN(rstN), .frameSelN(frameSelN), .serClk(serClk),
    .serData(serData), .ctrlWord(ctrlWord), .coreReset(coreReset),
    .freqWord0(freqWord0), .freqWord1(freqWord1),
    .phaseWord0(phaseWord0), .phaseWord1(phaseWord1)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "ctrl", {16'h0, ctrlWord}, {16'h0, mCtrl});
    chk(tag, "coreReset", {31'h0, coreReset}, {31'h0, mCtrl[8]});
    chk(tag, "freq0", {4'h0, freqWord0}, {4'h0, mF0});
    chk(tag, "freq1", {4'h0, freqWord1}, {4'h0, mF1});
    chk(tag, "phase0", {20'h0, phaseWord0}, {20'h0, mP0});
    chk(tag, "phase1", {20'h0, phaseWord1}, {20'h0, mP1});
  endtask

  function automatic string tagFor(input logic [15:0] w);
    if (w[15:14] == 2'b00) return "R3";
    if (w[15:14] == 2'b11) return "R9";
    if (mCtrl[13]) return "R6";
    return "R8";
  endfunction

  task automatic modelApply(input logic [15:0] w);
    logic        sel;
    logic [27:0] f;
    case (w[15:14])
      2'b00: begin mCtrl = w; mPend = 1'b0; end
      2'b11: if (w[13]) mP1 = w[11:0]; else mP0 = w[11:0];
      default: begin
        sel = w[15];
        f = sel ? mF1 : mF0;
        if (mCtrl[13]) begin
          if (mPend && mPendSel == sel) begin
            f = {w[13:0], mStage};
            mPend = 1'b0;
          end else begin
            mStage = w[13:0];
            mPend = 1'b1;
            mPendSel = sel;
          end
        end else if (mCtrl[12]) f[27:14] = w[13:0];
        else f[13:0] = w[13:0];
        if (sel) mF1 = f; else mF0 = f;
      end
    endcase
  endtask

  task automatic shiftFrame(input logic [15:0] w, input int nBits);
    @(negedge clk) frameSelN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      serData = (i < 16) ? w[15-i] : 1'($urandom);
      serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
      repeat (4) @(negedge clk);
    end
    serClk = 1'b1;
    repeat (4) @(negedge clk);
    frameSelN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w, input string tag);
    string t;
    t = (tag == "") ? tagFor(w) : tag;
    shiftFrame(w, 16);
    modelApply(w);
    checkAll(t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5_7A11));
    mCtrl = '0; mF0 = '0; mF1 = '0; mP0 = '0; mP1 = '0;
    mStage = '0; mPend = 1'b0; mPendSel = 1'b0;
    repeat (5) @(negedge clk);
    // R10 reset state
    checkAll("R10");
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3 control write with pair and soft-reset bits, R1 framing
    sendWord(16'h2100, "R3");
    sendWord(16'h2100, "R1");
    // R6 paired load: first half invisible, second loads both
    sendWord(16'h50C7, "R6");
    sendWord(16'h4123, "R6");
    chk("R6", "freq0 full", {4'h0, freqWord0}, {4'h0, 28'h048D0C7});
    // R9 phase with bit 12 ignored
    sendWord(16'hC000, "R9");
    sendWord(16'hDABC, "R9");
    chk("R9", "phase0 bit12", {20'h0, phaseWord0}, 32'h0ABC);
    sendWord(16'hE5A5, "R9");
    // R4 soft-reset bit leaves data registers alone
    sendWord(16'h2100, "R4");
    chk("R4", "freq0 kept", {4'h0, freqWord0}, {4'h0, 28'h048D0C7});
    // R7 restart with other register, then control write drops pending
    sendWord(16'h4011, "R7");
    sendWord(16'h8022, "R7");
    sendWord(16'h8033, "R7");
    chk("R7", "freq1 restart", {4'h0, freqWord1}, {4'h0, {14'h0033, 14'h0022}});
    chk("R7", "freq0 untouched", {4'h0, freqWord0}, {4'h0, 28'h048D0C7});
    sendWord(16'h4044, "R7");
    sendWord(16'h2000, "R7");
    sendWord(16'h4055, "R7");
    chk("R7", "freq0 after drop", {4'h0, freqWord0}, {4'h0, 28'h048D0C7});
    // R8 single-half writes, R5 addressing
    sendWord(16'h1000, "R8");
    sendWord(16'hBFFF, "R8");
    chk("R8", "freq1 upper", {4'h0, freqWord1}, {4'h0, {14'h3FFF, 14'h0022}});
    sendWord(16'h0000, "R8");
    sendWord(16'h5555, "R5");
    chk("R5", "freq0 lower", {4'h0, freqWord0[13:0]}, 32'h1555);
    // R2 truncated frame dropped
    shiftFrame(16'h0100, 10);
    checkAll("R2");
    shiftFrame(16'hC7FF, 15);
    checkAll("R2");
    // R2 overlong frame: first 16 bits taken
    shiftFrame(16'hF123, 21);
    modelApply(16'hF123);
    checkAll("R2");

    // R1 random words, biased toward frequency writes
    for (int n = 0; n < 260; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ((w[15:14] == 2'b00) && ($urandom % 3 != 0)) w[15:14] = 2'b01;
      sendWord(w, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule